// File: doc/BRIEF.md
# Opcode-Sequenced Half-Duplex SPI Master

This block is an SPI master whose bus activity is set by a small program rather than by software toggling pins. A 64-bit program word holds eight one-byte opcodes. The opcodes select a device, shift a number of bytes out of a 64-bit transmit word, shift a number of bytes into a 64-bit receive word, or stop. Writing the program word starts execution at slot 0, which is the top byte. Each opcode then runs to completion before the next slot is fetched.

Software reaches the block through a single-cycle register port. A write is a strobe with an index and a 64-bit value. A read returns data combinationally for the presented index, and the read strobe carries any side effect of the read. The register port has no back-pressure. Flow control for the data path is done with full flags in the status word: software writes a transmit word only when the transmit-full flag is clear, and reads the receive word once the receive-full flag is set. When a shift opcode finds its holding register unavailable, the sequencer waits with SCK idle. The bus runs in SPI mode 0 with an active-low select per device.

Top module: `seq_spi_master`

## Requirements
- R1: After reset, the status word (index 8) reads only bit 48 set, `cs_n` is all ones, `sck` and `mosi` are low, and the clock word (index 3) reads `DIV_INIT` in bits 63:52.
- R2: Writing the program word (index 7) starts execution at slot 0 (bits 63:56) and proceeds toward bits 7:0. An opcode with upper nibble 0 returns the block to idle. Execution also returns to idle after slot 7 completes, and `cs_n` keeps its last value in both cases.
- R3: Opcode 0x1n with n in 1..NCS drives only `cs_n[n-1]` low. Opcode 0x10 (and any n above NCS) drives all of `cs_n` high.
- R4: Opcode 0x3n (n from 1 to 8) sends the top n bytes of the transmit word, starting with bits 63:56, each byte MSB first. `mosi` changes only while `sck` is low and is sampled on the rising edge. `mosi` stays low during a shift-in.
- R5: Opcode 0x4n (n from 1 to 8) samples `miso` on rising edges and stores the n bytes right-aligned in the receive word (index 6), with the first byte received the most significant of the n. It then sets status bit 63.
- R6: A write to index 5 while bit 59 is clear loads the transmit word and sets bit 59. A shift-out that takes the word clears bit 59. A write while bit 59 is set leaves the word unchanged and sets bit 58.
- R7: A read strobe on index 6 clears bit 63. A read strobe on index 6 while bit 63 is clear sets bit 61.
- R8: A shift-out reached with bit 59 clear waits with `sck` low, sets bit 57, and continues once a transmit word is written. A shift-in reached with bit 63 set waits and sets bit 62.
- R9: Status bits 51:48 hold a one-hot state: 48 for idle, 49 for fetch or wait, 50 for shifting out, 51 for shifting in. A write to index 8 ANDs error bits 62, 61, 58 and 57 with the written value, so writing zero clears them.
- R10: While shifting, each high and low phase of `sck` lasts (divider+1) clocks. The divider is bits 63:52 of the last write to index 3.
- R11: A write to index 3 with bits 39:36 = 0101, followed by the next index-3 write with bits 39:36 = 1010, stops the sequencer, deselects all devices, and clears bits 59 and 63. Error bits are kept. A 1010 write without the preceding 0101 write does nothing to the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_idx | input | 4 | Register index for a write |
| reg_wr_data | input | 64 | Write value |
| reg_rd | input | 1 | Read strobe (carries the read side effects) |
| reg_rd_idx | input | 4 | Register index for a read |
| reg_rd_data | output | 64 | Read value for `reg_rd_idx` (combinational) |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low device selects |

## Verification
If the slot pointer or the opcode decode is wrong, the next byte on the bus carries the wrong select pattern or the wrong data. The scoreboard compares every byte against its expected select and value at the rising edge that completes the byte. If a holding flag is wrong, it shows up in the status word within one register access: a missed stall shows up as unexpected SCK edges, and a stuck flag keeps the sequencer out of idle, so the idle poll runs out. If the divider is wrong, the measured SCK high time changes on the first bit.

// File: rtl/seq_spi_pkg.sv
package seq_spi_pkg;
  localparam int WORD_W = 64;
  localparam int SLOTS  = 8;

  localparam logic [3:0] IDX_CLK  = 4'd3;
  localparam logic [3:0] IDX_TX   = 4'd5;
  localparam logic [3:0] IDX_RX   = 4'd6;
  localparam logic [3:0] IDX_PROG = 4'd7;
  localparam logic [3:0] IDX_STAT = 4'd8;

  localparam int B_RX_FULL = 63;
  localparam int B_RX_OVR  = 62;
  localparam int B_RX_UDR  = 61;
  localparam int B_TX_FULL = 59;
  localparam int B_TX_OVR  = 58;
  localparam int B_TX_UDR  = 57;
  localparam int B_STATE   = 48;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'b0001,
    ST_FETCH = 4'b0010,
    ST_OUT   = 4'b0100,
    ST_IN    = 4'b1000
  } seq_state_e;
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import seq_spi_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              dir_out,
  input  logic [3:0]        nbytes,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  localparam int BITS_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] sreg;
  logic [BITS_W-1:0] bits_left;
  logic [DIV_W-1:0]  phase;
  logic              active, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0; bits_left <= '0; phase <= '0;
      active <= 1'b0; dir_q <= 1'b0; sck <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sck    <= 1'b0;
      end else if (start) begin
        active    <= 1'b1;
        sck       <= 1'b0;
        phase     <= '0;
        dir_q     <= dir_out;
        bits_left <= BITS_W'({nbytes, 3'b000});
        sreg      <= dir_out ? tx_word : '0;
      end else if (active) begin
        if (phase == div) begin
          phase <= '0;
          sck   <= ~sck;
          if (!sck) begin
            // rising edge: capture
            if (!dir_q) sreg <= {sreg[WORD_W-2:0], miso};
          end else begin
            // falling edge: bit complete
            bits_left <= bits_left - 1'b1;
            if (bits_left == BITS_W'(1)) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else if (dir_q) begin
              sreg <= {sreg[WORD_W-2:0], 1'b0};
            end
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  assign mosi    = active & dir_q & sreg[WORD_W-1];
  assign rx_word = sreg;
endmodule

// File: rtl/seq_engine.sv
module seq_engine
  import seq_spi_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              soft_rst,
  input  logic [WORD_W-1:0] prog,
  input  logic              tx_full,
  input  logic              rx_full,
  input  logic              sh_done,
  output seq_state_e        state,
  output logic [NCS-1:0]    cs_n,
  output logic              sh_start,
  output logic              sh_dir_out,
  output logic [3:0]        sh_nbytes,
  output logic              tx_take,
  output logic              rx_load,
  output logic              tx_udr_evt,
  output logic              rx_ovr_evt
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] slot;
  logic [7:0]        op;
  logic              live, is_out, is_in, last;
  logic [NCS-1:0]    sel_n;

  always_comb begin
    op        = prog[WORD_W-8-8*int'(slot) +: 8];
    sh_nbytes = (op[3:0] > 4'd8) ? 4'd8 : op[3:0];
    live      = (state == ST_FETCH) && !go && !soft_rst;
    is_out    = (op[7:4] == 4'h3) && (sh_nbytes != 4'd0);
    is_in     = (op[7:4] == 4'h4) && (sh_nbytes != 4'd0);
    last      = (slot == SLOT_W'(SLOTS - 1));
  end

  generate
    for (genvar i = 0; i < NCS; i++) begin : g_sel
      assign sel_n[i] = (op[3:0] != 4'(i + 1));
    end
  endgenerate

  assign sh_dir_out = is_out;
  assign tx_take    = live && is_out && tx_full;
  assign tx_udr_evt = live && is_out && !tx_full;
  assign rx_ovr_evt = live && is_in && rx_full;
  assign sh_start   = tx_take || (live && is_in && !rx_full);
  assign rx_load    = (state == ST_IN) && sh_done && !go && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= '0;
      cs_n  <= '1;
    end else if (soft_rst) begin
      state <= ST_IDLE;
      cs_n  <= '1;
    end else if (go) begin
      state <= ST_FETCH;
      slot  <= '0;
    end else begin
      case (state)
        ST_FETCH: begin
          if (op[7:4] == 4'h0) begin
            state <= ST_IDLE;
          end else if (is_out) begin
            if (tx_full) state <= ST_OUT;
          end else if (is_in) begin
            if (!rx_full) state <= ST_IN;
          end else begin
            if (op[7:4] == 4'h1) cs_n <= sel_n;
            if (last) state <= ST_IDLE;
            else      slot  <= slot + 1'b1;
          end
        end
        ST_OUT, ST_IN: begin
          if (sh_done) begin
            if (last) state <= ST_IDLE;
            else begin
              state <= ST_FETCH;
              slot  <= slot + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seq_spi_master.sv
module seq_spi_master
  import seq_spi_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int DIV_W    = 12,
  parameter int DIV_INIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_wr_idx,
  input  logic [WORD_W-1:0] reg_wr_data,
  input  logic              reg_rd,
  input  logic [3:0]        reg_rd_idx,
  output logic [WORD_W-1:0] reg_rd_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  localparam int DIV_LSB = WORD_W - DIV_W;

  logic [DIV_W-1:0]  clk_div;
  logic [WORD_W-1:0] tx_word, rx_word, prog;
  logic              tx_full, rx_full, armed;
  logic              tx_ovr, tx_udr, rx_ovr, rx_udr;
  logic              wr_clk, wr_tx, wr_prog, wr_stat, rd_rx;
  logic              pat_a, pat_b, soft_rst, go;
  seq_state_e        state;
  logic              sh_start, sh_dir_out, sh_done;
  logic [3:0]        sh_nbytes;
  logic [WORD_W-1:0] sh_rx;
  logic              tx_take, rx_load, tx_udr_evt, rx_ovr_evt;

  assign wr_clk   = reg_wr && (reg_wr_idx == IDX_CLK);
  assign wr_tx    = reg_wr && (reg_wr_idx == IDX_TX);
  assign wr_prog  = reg_wr && (reg_wr_idx == IDX_PROG);
  assign wr_stat  = reg_wr && (reg_wr_idx == IDX_STAT);
  assign rd_rx    = reg_rd && (reg_rd_idx == IDX_RX);
  assign pat_a    = (reg_wr_data[39:36] == 4'b0101);
  assign pat_b    = (reg_wr_data[39:36] == 4'b1010);
  assign soft_rst = wr_clk && armed && pat_b;
  assign go       = wr_prog;

  seq_engine #(.NCS(NCS)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .soft_rst(soft_rst), .prog(prog),
    .tx_full(tx_full), .rx_full(rx_full), .sh_done(sh_done),
    .state(state), .cs_n(cs_n), .sh_start(sh_start), .sh_dir_out(sh_dir_out),
    .sh_nbytes(sh_nbytes), .tx_take(tx_take), .rx_load(rx_load),
    .tx_udr_evt(tx_udr_evt), .rx_ovr_evt(rx_ovr_evt)
  );

  spi_shift_engine #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(soft_rst || go), .start(sh_start),
    .dir_out(sh_dir_out), .nbytes(sh_nbytes), .tx_word(tx_word), .div(clk_div),
    .miso(miso), .done(sh_done), .rx_word(sh_rx), .sck(sck), .mosi(mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_div <= DIV_W'(DIV_INIT);
      armed   <= 1'b0;
      prog    <= '0;
      tx_word <= '0; tx_full <= 1'b0;
      rx_word <= '0; rx_full <= 1'b0;
      tx_ovr  <= 1'b0; tx_udr <= 1'b0; rx_ovr <= 1'b0; rx_udr <= 1'b0;
    end else begin
      if (wr_clk) begin
        clk_div <= reg_wr_data[WORD_W-1:DIV_LSB];
        armed   <= pat_a;
      end
      if (wr_prog) prog <= reg_wr_data;

      if (wr_stat) begin
        tx_ovr <= tx_ovr & reg_wr_data[B_TX_OVR];
        tx_udr <= tx_udr & reg_wr_data[B_TX_UDR];
        rx_ovr <= rx_ovr & reg_wr_data[B_RX_OVR];
        rx_udr <= rx_udr & reg_wr_data[B_RX_UDR];
      end
      if (wr_tx && tx_full && !tx_take) tx_ovr <= 1'b1;
      if (tx_udr_evt) tx_udr <= 1'b1;
      if (rx_ovr_evt) rx_ovr <= 1'b1;
      if (rd_rx && !rx_full) rx_udr <= 1'b1;

      if (soft_rst) begin
        tx_full <= 1'b0;
        rx_full <= 1'b0;
      end else begin
        if (wr_tx && (!tx_full || tx_take)) begin
          tx_word <= reg_wr_data;
          tx_full <= 1'b1;
        end else if (tx_take) begin
          tx_full <= 1'b0;
        end
        if (rx_load) begin
          rx_word <= sh_rx;
          rx_full <= 1'b1;
        end else if (rd_rx) begin
          rx_full <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rd_data = '0;
    case (reg_rd_idx)
      IDX_CLK:  reg_rd_data[WORD_W-1:DIV_LSB] = clk_div;
      IDX_TX:   reg_rd_data = tx_word;
      IDX_RX:   reg_rd_data = rx_word;
      IDX_PROG: reg_rd_data = prog;
      IDX_STAT: begin
        reg_rd_data[B_RX_FULL]         = rx_full;
        reg_rd_data[B_RX_OVR]          = rx_ovr;
        reg_rd_data[B_RX_UDR]          = rx_udr;
        reg_rd_data[B_TX_FULL]         = tx_full;
        reg_rd_data[B_TX_OVR]          = tx_ovr;
        reg_rd_data[B_TX_UDR]          = tx_udr;
        reg_rd_data[B_STATE +: 4]      = state;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/seq_spi_checker.sv
module seq_spi_checker
  import seq_spi_pkg::*;
#(
  parameter int NCS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [3:0]        reg_wr_idx,
  input logic              reg_rd,
  input logic [3:0]        reg_rd_idx,
  input logic              sck,
  input logic [NCS-1:0]    cs_n,
  input logic              tx_full,
  input logic              rx_full,
  input logic              tx_ovr,
  input logic              tx_take,
  input logic [WORD_W-1:0] tx_word,
  input logic              soft_rst,
  input seq_state_e        state
);
  // R3: at most one device selected
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R9: state field is one-hot
  a_r9_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state));

  // R8: no clock activity while idle or waiting in fetch
  a_r8_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_FETCH) |-> !sck);

  // R6: write to a full transmit word flags overrun and keeps the word
  a_r6_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wr_idx == IDX_TX && tx_full && !tx_take && !soft_rst)
      |=> (tx_ovr && $stable(tx_word)));

  // R7: read strobe on the receive word empties it
  a_r7_rx_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_rd_idx == IDX_RX && rx_full) |=> !rx_full);

  // R11: second reset step idles and empties both holding words
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!tx_full && !rx_full && state == ST_IDLE && cs_n == '1));
endmodule

bind seq_spi_master seq_spi_checker #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wr_idx(reg_wr_idx),
  .reg_rd(reg_rd), .reg_rd_idx(reg_rd_idx), .sck(sck), .cs_n(cs_n),
  .tx_full(tx_full), .rx_full(rx_full), .tx_ovr(tx_ovr), .tx_take(tx_take),
  .tx_word(tx_word), .soft_rst(soft_rst), .state(state)
);

// File: tb/tb_seq_spi_master.sv
module tb_seq_spi_master;
  localparam int NCS = 4;
  localparam logic [63:0] ST_IDLE_ONLY = 64'h0001_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_wr_idx = '0, reg_rd_idx = '0;
  logic [63:0] reg_wr_data = '0;
  logic [63:0] reg_rd_data;
  logic        sck, mosi, miso;
  logic [NCS-1:0] cs_n;

  int total = 0, bad = 0;
  bit finished = 0;

  seq_spi_master #(.NCS(NCS), .DIV_W(12), .DIV_INIT(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data), .reg_rd(reg_rd), .reg_rd_idx(reg_rd_idx),
    .reg_rd_data(reg_rd_data), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- miso source: one bit per sck fall ----------------
  int          fall_cnt = 0;
  int          fall_base = 0;
  logic [63:0] miso_src = '0;
  always @(negedge sck) fall_cnt++;
  always_comb begin
    int pos;
    pos  = fall_cnt - fall_base;
    miso = (pos >= 0 && pos < 64) ? miso_src[63 - pos] : 1'b0;
  end

  // ---------------- scoreboard for bus bytes ----------------
  logic [NCS+7:0] expq[$];
  logic [7:0]     bitbuf = '0;
  int             nbits = 0;
  int             rise_cnt = 0;

  task automatic expect_byte(input logic [NCS-1:0] cs, input logic [7:0] b);
    expq.push_back({cs, b});
  endtask

  always @(posedge sck) begin
    logic [NCS+7:0] e;
    rise_cnt++;
    bitbuf = {bitbuf[6:0], mosi};
    nbits++;
    if (nbits == 8) begin
      nbits = 0;
      if (expq.size() == 0) begin
        check(1'b0, "R4 unexpected byte", 64'({cs_n, bitbuf}), 64'h0);
      end else begin
        e = expq.pop_front();
        check({cs_n, bitbuf} == e, "R4/R3 bus byte and select",
              64'({cs_n, bitbuf}), 64'(e));
      end
    end
  end

  int hi_run = 0, last_hi = 0;
  always @(negedge clk) begin
    if (sck) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  // ---------------- register access tasks ----------------
  task automatic wr(input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_rd_idx = idx;
    #1 d = reg_rd_data;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [63:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(4'd8, s);
      if (s[48]) return;
    end
    check(1'b0, tag, s, ST_IDLE_ONLY);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [63:0] v;
    int r0;
    miso_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd8, v); check(v == ST_IDLE_ONLY, "R1 status after reset", v, ST_IDLE_ONLY);
    check(cs_n == 4'hF && !sck && !mosi, "R1 pins after reset",
          64'({cs_n, sck, mosi}), 64'h3C);
    rd(4'd3, v); check(v == 64'h0010_0000_0000_0000, "R1 divider init", v, 64'h0010_0000_0000_0000);

    // R4/R6/R2/R10: three bytes out on device 0, then deselect and stop
    wr(4'd5, 64'hA1B2_C3D4_E5F6_0718);
    rd(4'd8, v); check(v == 64'h0801_0000_0000_0000, "R6 tx full set", v, 64'h0801_0000_0000_0000);
    expect_byte(4'b1110, 8'hA1); expect_byte(4'b1110, 8'hB2); expect_byte(4'b1110, 8'hC3);
    wr(4'd7, 64'h1133_1000_0000_0000);
    wait_idle("R2 idle after stop");
    rd(4'd8, v); check(v == ST_IDLE_ONLY, "R6 tx full cleared by shift", v, ST_IDLE_ONLY);
    check(cs_n == 4'hF, "R3 deselect opcode", 64'(cs_n), 64'hF);
    check(last_hi == 2, "R10 sck high time div 1", 64'(last_hi), 64'd2);

    // R6 overrun, R9 clear, R7 underrun
    wr(4'd5, 64'h3C11_2233_4455_6677);
    wr(4'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'd8, v); check(v == 64'h0C01_0000_0000_0000, "R6 tx overrun flag", v, 64'h0C01_0000_0000_0000);
    rd(4'd5, v); check(v == 64'h3C11_2233_4455_6677, "R6 word kept on overrun", v, 64'h3C11_2233_4455_6677);
    wr(4'd8, 64'h0);
    rd(4'd8, v); check(v == 64'h0801_0000_0000_0000, "R9 status write clears errors", v, 64'h0801_0000_0000_0000);
    rd(4'd6, v);
    rd(4'd8, v); check(v == 64'h2801_0000_0000_0000, "R7 rx underrun flag", v, 64'h2801_0000_0000_0000);
    wr(4'd8, 64'h0);

    // R5: one byte out on device 1, two bytes in
    fall_base = fall_cnt;
    miso_src  = {8'h00, 8'h5A, 8'hC3, 40'h0};
    expect_byte(4'b1101, 8'h3C); expect_byte(4'b1101, 8'h00); expect_byte(4'b1101, 8'h00);
    wr(4'd7, 64'h1231_4210_0000_0000);
    wait_idle("R2 idle after rx program");
    rd(4'd8, v); check(v == 64'h8001_0000_0000_0000, "R5 rx full set", v, 64'h8001_0000_0000_0000);
    rd(4'd6, v); check(v == 64'h0000_0000_0000_5AC3, "R5 rx right aligned", v, 64'h5AC3);
    rd(4'd8, v); check(v == ST_IDLE_ONLY, "R7 read clears rx full", v, ST_IDLE_ONLY);

    // R8: shift-out with empty transmit word waits
    wr(4'd7, 64'h1331_1000_0000_0000);
    r0 = rise_cnt;
    repeat (40) @(negedge clk);
    check(rise_cnt == r0, "R8 no sck while tx empty", 64'(rise_cnt - r0), 64'd0);
    rd(4'd8, v); check(v == 64'h0202_0000_0000_0000, "R8 tx underrun and wait state", v, 64'h0202_0000_0000_0000);
    check(cs_n == 4'b1011, "R3 select device 3", 64'(cs_n), 64'hB);
    expect_byte(4'b1011, 8'h77);
    wr(4'd5, 64'h7700_0000_0000_0000);
    wait_idle("R8 resume after tx write");
    rd(4'd8, v); check(v == 64'h0201_0000_0000_0000, "R8 resumed to idle", v, 64'h0201_0000_0000_0000);
    wr(4'd8, 64'h0);

    // R8 rx wait, then R11 two-step reset
    fall_base = fall_cnt;
    miso_src  = {8'h9E, 56'h0};
    expect_byte(4'b1110, 8'h00);
    wr(4'd7, 64'h1141_1000_0000_0000);
    wait_idle("R5 single rx byte");
    wr(4'd7, 64'h1141_1000_0000_0000);
    repeat (10) @(negedge clk);
    rd(4'd8, v); check(v == 64'hC002_0000_0000_0000, "R8 rx overrun and wait", v, 64'hC002_0000_0000_0000);
    wr(4'd3, 64'h0000_00A0_0000_0000);
    rd(4'd8, v); check(v == 64'hC002_0000_0000_0000, "R11 lone second step ignored", v, 64'hC002_0000_0000_0000);
    wr(4'd3, 64'h0000_0050_0000_0000);
    wr(4'd3, 64'h0000_00A0_0000_0000);
    rd(4'd8, v); check(v == 64'h4001_0000_0000_0000, "R11 reset idles and empties", v, 64'h4001_0000_0000_0000);
    check(cs_n == 4'hF, "R11 reset deselects", 64'(cs_n), 64'hF);
    wr(4'd8, 64'h0);

    // R10: divider 3
    wr(4'd3, 64'h0030_0000_0000_0000);
    rd(4'd3, v); check(v == 64'h0030_0000_0000_0000, "R10 divider readback", v, 64'h0030_0000_0000_0000);
    wr(4'd5, 64'hF055_0000_0000_0000);
    expect_byte(4'b1110, 8'hF0);
    wr(4'd7, 64'h1131_1000_0000_0000);
    wait_idle("R10 idle after slow byte");
    check(last_hi == 4, "R10 sck high time div 3", 64'(last_hi), 64'd4);

    // R2: eight non-stop opcodes end after slot 7, select held
    wr(4'd7, 64'h1111_1111_1111_1114);
    wait_idle("R2 idle after slot 7");
    rd(4'd8, v); check(v == ST_IDLE_ONLY, "R2 idle after last slot", v, ST_IDLE_ONLY);
    check(cs_n == 4'b0111, "R2 select held after slot 7", 64'(cs_n), 64'h7);

    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R4 all expected bytes seen", 64'(expq.size()), 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R2 run did not end actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule